// File: doc/BRIEF.md
# Dual-Port Semaphore Token Bank

This block holds a small set of hardware semaphores that two agents, a left port and a right port, use to claim shared resources. Each port has its own select, index, write strobe, read strobe and data bus, and both run on one clock. A port asks for a token by writing a zero and gives it back by writing a one. A read returns all zeros when that port holds the token and all ones in every other case.

A request made while the other side holds the token stays pending. The token then passes to the waiting side in the same cycle as the release. When both ports request a free token in the same cycle, the left port wins and the right request stays pending. Read data is captured in a register when a read access begins and is held for as long as that access lasts.

Top module: `sema_bank`

## Requirements
- R1: After the synchronous active-high reset, every semaphore is free, both read buses are zero, and a read of any index on either port returns all ones.
- R2: The semaphore index is the lowest clog2(NUM_SEM) address bits (bits 2:0 by default). Higher address bits have no effect.
- R3: A port acts only when its select is high and its memory enable is low. With both high, or with select low, a write changes nothing.
- R4: A write uses only data bit 0: 0 requests or keeps the token, 1 releases it or cancels a request. All other data bits are ignored.
- R5: A free semaphore reads all ones on both ports. Once one side takes it, that side reads all zeros and the other side reads all ones on every data bit.
- R6: A zero written by the non-owner does not change what either port reads, and ownership stays with the owner.
- R7: When the owner writes one while the other side has a pending request, ownership passes to the other side at that clock edge.
- R8: When the owner writes one and no request is pending, the semaphore becomes free.
- R9: A read access (select high, memory enable low, read strobe high, write strobe low) captures the value at its first clock edge. The value appears on the read bus after that edge and stays unchanged while the access continues on the same index, even if the other port changes the semaphore.
- R10: When both ports write zero to a free semaphore in the same cycle, the left port becomes owner and the right request is recorded as pending.
- R11: A non-owner that writes one clears its own pending request, so a later release by the owner leaves the semaphore free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst | input | 1 | Synchronous active-high reset |
| l_sel | input | 1 | Left semaphore select, active high |
| l_mem_en | input | 1 | Left memory enable, active high; blocks semaphore access |
| l_addr | input | ADDR_W | Left address; low bits pick the semaphore |
| l_wr | input | 1 | Left write strobe |
| l_rd | input | 1 | Left read strobe |
| l_wdata | input | DATA_W | Left write data; bit 0 used |
| l_rdata | output | DATA_W | Left registered read data |
| r_sel | input | 1 | Right semaphore select, active high |
| r_mem_en | input | 1 | Right memory enable, active high; blocks semaphore access |
| r_addr | input | ADDR_W | Right address; low bits pick the semaphore |
| r_wr | input | 1 | Right write strobe |
| r_rd | input | 1 | Right read strobe |
| r_wdata | input | DATA_W | Right write data; bit 0 used |
| r_rdata | output | DATA_W | Right registered read data |

## Verification
The state of a semaphore is visible only through reads, so a wrong owner, a lost pending request or a stale free state shows up as an inverted read bus. It appears on the first read that starts after the faulty edge, one clock after that read begins. A pending flag that is lost or kept by mistake shows no sign until the owner releases. The tests therefore always follow a release with reads on both ports. A read register that fails to hold its value shows up only while the other port changes the semaphore during a long read, and the freeze test sets up exactly that case.

// File: rtl/sema_pkg.sv
package sema_pkg;
  typedef enum logic {SIDE_L = 1'b0, SIDE_R = 1'b1} side_e;

  typedef struct packed {
    logic  held;
    side_e side;
    logic  l_wait;
    logic  r_wait;
  } sem_state_t;
endpackage

// File: rtl/sema_port_decode.sv
module sema_port_decode #(
  parameter int NUM_SEM = 8,
  parameter int ADDR_W  = 15,
  parameter int DATA_W  = 9
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       sel,
  input  logic                       mem_en,
  input  logic [ADDR_W-1:0]          addr,
  input  logic                       wr_en,
  input  logic                       rd_en,
  input  logic [DATA_W-1:0]          wdata,
  output logic [NUM_SEM-1:0]         req_vec,
  output logic [NUM_SEM-1:0]         rel_vec,
  output logic                       rd_act,
  output logic [$clog2(NUM_SEM)-1:0] rd_idx
);
  localparam int IDX_W = $clog2(NUM_SEM);

  logic             access;
  logic [IDX_W-1:0] idx;
  logic             unused_bits;

  assign access      = sel && !mem_en;
  assign idx         = addr[IDX_W-1:0];
  assign rd_act      = access && rd_en && !wr_en;
  assign rd_idx      = idx;
  assign unused_bits = ^{addr[ADDR_W-1:IDX_W], wdata[DATA_W-1:1]};

  for (genvar g = 0; g < NUM_SEM; g++) begin : g_hit
    logic hit;
    assign hit        = access && wr_en && (idx == IDX_W'(g));
    assign req_vec[g] = hit && !wdata[0];
    assign rel_vec[g] = hit && wdata[0];
  end

  // R3: an illegal or deselected port must produce no write command
  a_r3_blocked: assert property (@(posedge clk) disable iff (rst)
    (!sel || mem_en) |-> ($countones({req_vec, rel_vec}) == 0));
  // R2: at most one semaphore is addressed per port per cycle
  a_r2_single: assert property (@(posedge clk) disable iff (rst)
    $onehot0(req_vec | rel_vec));
endmodule

// File: rtl/sema_cell.sv
module sema_cell
  import sema_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       l_req,
  input  logic       l_rel,
  input  logic       r_req,
  input  logic       r_rel,
  output sem_state_t state_q
);
  sem_state_t nxt;
  logic       r_w, l_w;

  always_comb begin
    nxt = state_q;
    r_w = r_req ? 1'b1 : (r_rel ? 1'b0 : state_q.r_wait);
    l_w = l_req ? 1'b1 : (l_rel ? 1'b0 : state_q.l_wait);
    if (!state_q.held) begin
      nxt.l_wait = 1'b0;
      nxt.r_wait = l_req && r_req;
      if (l_req) begin
        nxt.held = 1'b1;
        nxt.side = SIDE_L;
      end else if (r_req) begin
        nxt.held = 1'b1;
        nxt.side = SIDE_R;
      end
    end else if (state_q.side == SIDE_L) begin
      nxt.l_wait = 1'b0;
      if (l_rel) begin
        nxt.r_wait = 1'b0;
        if (r_w) nxt.side = SIDE_R;
        else     nxt.held = 1'b0;
      end else begin
        nxt.r_wait = r_w;
      end
    end else begin
      nxt.r_wait = 1'b0;
      if (r_rel) begin
        nxt.l_wait = 1'b0;
        if (l_w) nxt.side = SIDE_L;
        else     nxt.held = 1'b0;
      end else begin
        nxt.l_wait = l_w;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= '0;
    else     state_q <= nxt;
  end

  // R6: owner keeps the token unless it releases
  a_r6_keep_l: assert property (@(posedge clk) disable iff (rst)
    (state_q.held && state_q.side == SIDE_L && !l_rel) |=> (state_q.held && state_q.side == SIDE_L));
  a_r6_keep_r: assert property (@(posedge clk) disable iff (rst)
    (state_q.held && state_q.side == SIDE_R && !r_rel) |=> (state_q.held && state_q.side == SIDE_R));
  // R7: release with a waiting peer hands the token over
  a_r7_handover: assert property (@(posedge clk) disable iff (rst)
    (state_q.held && state_q.side == SIDE_L && l_rel && state_q.r_wait && !r_rel)
      |=> (state_q.held && state_q.side == SIDE_R));
  // R8: release with nobody waiting frees the semaphore
  a_r8_free: assert property (@(posedge clk) disable iff (rst)
    (state_q.held && state_q.side == SIDE_R && r_rel && !state_q.l_wait && !l_req) |=> !state_q.held);
  // R10: a tie on a free semaphore goes to the left with the right pending
  a_r10_tie: assert property (@(posedge clk) disable iff (rst)
    (!state_q.held && l_req && r_req) |=> (state_q.held && state_q.side == SIDE_L && state_q.r_wait));
  // R11: a cancel by the non-owner drops its request
  a_r11_cancel: assert property (@(posedge clk) disable iff (rst)
    (state_q.held && state_q.side == SIDE_L && r_rel && !l_rel) |=> !state_q.r_wait);
endmodule

// File: rtl/sema_read_reg.sv
module sema_read_reg #(
  parameter int NUM_SEM = 8,
  parameter int DATA_W  = 9
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       rd_act,
  input  logic [$clog2(NUM_SEM)-1:0] rd_idx,
  input  logic [NUM_SEM-1:0]         owns_vec,
  output logic [DATA_W-1:0]          rdata
);
  localparam int IDX_W = $clog2(NUM_SEM);

  logic             prev_act;
  logic [IDX_W-1:0] prev_idx;
  logic             start;

  assign start = rd_act && (!prev_act || (rd_idx != prev_idx));

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_act <= 1'b0;
      prev_idx <= '0;
      rdata    <= '0;
    end else begin
      prev_act <= rd_act;
      prev_idx <= rd_idx;
      if (start) rdata <= {DATA_W{!owns_vec[rd_idx]}};
    end
  end

  // R9: read bus holds while an access continues
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (rd_act && !start) |=> $stable(rdata));
  // R5: every bit of the read bus carries the same value
  a_r5_uniform: assert property (@(posedge clk) disable iff (rst)
    (rdata == '0) || (rdata == '1));
endmodule

// File: rtl/sema_bank.sv
module sema_bank
  import sema_pkg::*;
#(
  parameter int NUM_SEM = 8,
  parameter int ADDR_W  = 15,
  parameter int DATA_W  = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              l_sel,
  input  logic              l_mem_en,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              l_wr,
  input  logic              l_rd,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  input  logic              r_sel,
  input  logic              r_mem_en,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              r_wr,
  input  logic              r_rd,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata
);
  localparam int IDX_W = $clog2(NUM_SEM);

  logic [NUM_SEM-1:0] l_req, l_rel, r_req, r_rel, l_owns, r_owns;
  logic               l_act, r_act;
  logic [IDX_W-1:0]   l_idx, r_idx;

  sema_port_decode #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec_l (
    .clk(clk), .rst(rst), .sel(l_sel), .mem_en(l_mem_en), .addr(l_addr), .wr_en(l_wr),
    .rd_en(l_rd), .wdata(l_wdata), .req_vec(l_req), .rel_vec(l_rel), .rd_act(l_act), .rd_idx(l_idx));

  sema_port_decode #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec_r (
    .clk(clk), .rst(rst), .sel(r_sel), .mem_en(r_mem_en), .addr(r_addr), .wr_en(r_wr),
    .rd_en(r_rd), .wdata(r_wdata), .req_vec(r_req), .rel_vec(r_rel), .rd_act(r_act), .rd_idx(r_idx));

  for (genvar g = 0; g < NUM_SEM; g++) begin : g_sem
    sem_state_t st;
    sema_cell u_cell (
      .clk(clk), .rst(rst), .l_req(l_req[g]), .l_rel(l_rel[g]),
      .r_req(r_req[g]), .r_rel(r_rel[g]), .state_q(st));
    assign l_owns[g] = st.held && (st.side == SIDE_L);
    assign r_owns[g] = st.held && (st.side == SIDE_R);
  end

  sema_read_reg #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_rd_l (
    .clk(clk), .rst(rst), .rd_act(l_act), .rd_idx(l_idx), .owns_vec(l_owns), .rdata(l_rdata));

  sema_read_reg #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_rd_r (
    .clk(clk), .rst(rst), .rd_act(r_act), .rd_idx(r_idx), .owns_vec(r_owns), .rdata(r_rdata));

  // R5: a token never has two owners
  a_r5_exclusive: assert property (@(posedge clk) disable iff (rst)
    (l_owns & r_owns) == '0);
endmodule

// File: tb/sema_bank_tb.sv
module sema_bank_tb_top;
  localparam int CLK_P   = 10;
  localparam int NUM_SEM = 8;
  localparam int ADDR_W  = 15;
  localparam int DATA_W  = 9;
  localparam logic [DATA_W-1:0] ONES = '1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic l_sel = 0, l_mem_en = 0, l_wr = 0, l_rd = 0;
  logic r_sel = 0, r_mem_en = 0, r_wr = 0, r_rd = 0;
  logic [ADDR_W-1:0] l_addr = '0, r_addr = '0;
  logic [DATA_W-1:0] l_wdata = '0, r_wdata = '0, l_rdata, r_rdata;
  int checks = 0, errors = 0;

  always #(CLK_P/2) clk = ~clk;

  sema_bank #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst(rst),
    .l_sel(l_sel), .l_mem_en(l_mem_en), .l_addr(l_addr), .l_wr(l_wr), .l_rd(l_rd),
    .l_wdata(l_wdata), .l_rdata(l_rdata),
    .r_sel(r_sel), .r_mem_en(r_mem_en), .r_addr(r_addr), .r_wr(r_wr), .r_rd(r_rd),
    .r_wdata(r_wdata), .r_rdata(r_rdata));

  task automatic check(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    l_sel = 0; l_mem_en = 0; l_wr = 0; l_rd = 0;
    r_sel = 0; r_mem_en = 0; r_wr = 0; r_rd = 0;
  endtask

  // side 0 = left, 1 = right; called at a falling edge
  task automatic wr(input bit side, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                    input bit sel = 1'b1, input bit mem = 1'b0);
    if (!side) begin l_sel = sel; l_mem_en = mem; l_addr = a; l_wdata = d; l_wr = 1; end
    else       begin r_sel = sel; r_mem_en = mem; r_addr = a; r_wdata = d; r_wr = 1; end
    @(negedge clk);
    idle();
  endtask

  task automatic wr_both(input logic [2:0] idx, input logic [DATA_W-1:0] dl, input logic [DATA_W-1:0] dr);
    l_sel = 1; l_addr = ADDR_W'(idx); l_wdata = dl; l_wr = 1;
    r_sel = 1; r_addr = ADDR_W'(idx); r_wdata = dr; r_wr = 1;
    @(negedge clk);
    idle();
  endtask

  task automatic rd(input bit side, input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] v);
    if (!side) begin l_sel = 1; l_addr = a; l_rd = 1; end
    else       begin r_sel = 1; r_addr = a; r_rd = 1; end
    @(negedge clk);
    v = side ? r_rdata : l_rdata;
    idle();
    @(negedge clk);
  endtask

  task automatic expect_pair(input string req, input logic [2:0] idx,
                             input logic [DATA_W-1:0] el, input logic [DATA_W-1:0] er);
    logic [DATA_W-1:0] v;
    rd(1'b0, ADDR_W'(idx), v); check({req, " left"}, v, el);
    rd(1'b1, ADDR_W'(idx), v); check({req, " right"}, v, er);
  endtask

  task automatic t_reset();
    check("R1 left rdata after reset", l_rdata, '0);
    check("R1 right rdata after reset", r_rdata, '0);
    for (int i = 0; i < NUM_SEM; i++) expect_pair("R1 free after reset", 3'(i), ONES, ONES);
  endtask

  task automatic t_take_pass_free();
    wr(1'b0, 15'd2, 9'h000);
    expect_pair("R5 left owns", 3'd2, '0, ONES);
    wr(1'b1, 15'd2, 9'h000);
    expect_pair("R6 non-owner request", 3'd2, '0, ONES);
    wr(1'b0, 15'd2, 9'h001);
    expect_pair("R7 handover to right", 3'd2, ONES, '0);
    wr(1'b1, 15'd2, 9'h001);
    expect_pair("R8 release to free", 3'd2, ONES, ONES);
  endtask

  task automatic t_index();
    wr(1'b0, 15'h7ABD, 9'h000);
    expect_pair("R2 upper bits ignored idx5", 3'd5, '0, ONES);
    expect_pair("R2 neighbour idx4 untouched", 3'd4, ONES, ONES);
    wr(1'b0, 15'h0005, 9'h001);
  endtask

  task automatic t_illegal();
    wr(1'b1, 15'd6, 9'h000, 1'b1, 1'b1);
    expect_pair("R3 select with memory enable", 3'd6, ONES, ONES);
    wr(1'b1, 15'd6, 9'h000, 1'b0, 1'b0);
    expect_pair("R3 deselected write", 3'd6, ONES, ONES);
  endtask

  task automatic t_bit0();
    wr(1'b0, 15'd1, 9'h1FE);
    expect_pair("R4 bit0 zero takes", 3'd1, '0, ONES);
    wr(1'b0, 15'd1, 9'h001);
    expect_pair("R4 bit0 one releases", 3'd1, ONES, ONES);
  endtask

  task automatic t_tie();
    wr_both(3'd3, 9'h000, 9'h000);
    expect_pair("R10 tie goes left", 3'd3, '0, ONES);
    wr(1'b0, 15'd3, 9'h001);
    expect_pair("R10 right pending granted", 3'd3, ONES, '0);
    wr(1'b1, 15'd3, 9'h001);
  endtask

  task automatic t_cancel();
    wr(1'b0, 15'd0, 9'h000);
    wr(1'b1, 15'd0, 9'h000);
    wr(1'b1, 15'd0, 9'h001);
    expect_pair("R11 cancel keeps left", 3'd0, '0, ONES);
    wr(1'b0, 15'd0, 9'h001);
    expect_pair("R11 cancelled request not granted", 3'd0, ONES, ONES);
  endtask

  task automatic t_freeze();
    wr(1'b0, 15'd7, 9'h000);
    wr(1'b1, 15'd7, 9'h000);
    r_sel = 1; r_addr = 15'd7; r_rd = 1;
    check("R9 value not shown before first edge", r_rdata, ONES);
    @(negedge clk);
    check("R9 captured value", r_rdata, ONES);
    l_sel = 1; l_addr = 15'd7; l_wdata = 9'h001; l_wr = 1;
    @(negedge clk);
    l_sel = 0; l_wr = 0;
    @(negedge clk);
    check("R9 frozen during other-port release", r_rdata, ONES);
    @(negedge clk);
    check("R9 still frozen", r_rdata, ONES);
    idle();
    @(negedge clk);
    expect_pair("R9 new read sees handover", 3'd7, ONES, '0);
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_take_pass_free();
    t_index();
    t_illegal();
    t_bit0();
    t_tie();
    t_cancel();
    t_freeze();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule